// File: doc/BRIEF.md
# Two-Phase Persistent Flush Sequencer

This host-side controller coordinates a global flush across a set of attached memory devices when the host raises a flush trigger, for example on a warning of imminent power loss. It first has every device halt new traffic and drain its caches. A one-cycle barrier follows. It then has every device commit its buffered writes to persistent media. Each device has its own request and acknowledge pair for each phase. A device acknowledges with a pulse or a level, and the sequencer remembers every acknowledge it has seen within the current phase.

Each phase is bounded by a cycle timeout taken from the `tmo_limit_i` input, and the count restarts when each phase begins. If the cache phase times out, the media phase still runs, and a failure flag is broadcast to all devices alongside the commit request so that each can record an unclean shutdown. The sequence ends with a one-cycle done pulse and a status code.

States: IDLE (waiting), DRAIN (phase one), BARRIER (no requests), COMMIT (phase two), FINISH (done pulse). Transitions: IDLE→DRAIN on trigger; DRAIN→BARRIER when all devices have acknowledged or on timeout; BARRIER→COMMIT always; COMMIT→FINISH when all devices have acknowledged or on timeout; FINISH→IDLE always.

Top module: `flush_seq`

## Requirements
- R1: After reset, all requests, fail flags, `done_o` and `busy_o` are low and `status_o` is 0.
- R2: A trigger sampled in IDLE raises `drain_req_o` on every device and `busy_o` from the next cycle on.
- R3: DRAIN keeps every drain request high until each device has acknowledged at least once in that phase. Acknowledges may be single-cycle pulses at different times.
- R4: Exactly one cycle with no request separates DRAIN from COMMIT, and drain and commit requests are never high together.
- R5: COMMIT raises `commit_req_o` on every device and ends once each device has acknowledged at least once in that phase.
- R6: Each phase counts its cycles from 0 at entry. A phase in which not all devices have acknowledged ends after `tmo_limit_i`+1 cycles. A complete set of acknowledges in that last cycle still counts as success.
- R7: After a drain timeout, COMMIT still runs, and `fail_o` is high on every device throughout COMMIT. `fail_o` is low at all other times.
- R8: `done_o` is a one-cycle pulse in FINISH. `status_o` is then 0 for success, 1 for a drain timeout (this code wins if both phases time out) and 2 for a commit timeout only. It holds until the next accepted trigger, which resets it to 0.
- R9: A trigger that arrives while `busy_o` is high is ignored and starts no new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Flush trigger from the host |
| tmo_limit_i | input | TMO_W | Per-phase timeout limit in cycles |
| drain_req_o | output | N_DEV | Phase-one request per device |
| drain_ack_i | input | N_DEV | Phase-one acknowledge per device |
| commit_req_o | output | N_DEV | Phase-two request per device |
| commit_ack_i | input | N_DEV | Phase-two acknowledge per device |
| fail_o | output | N_DEV | Phase-one failure flag per device |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | Result code |
| busy_o | output | 1 | Sequence in progress |

## Verification
A trigger sampled at a clock edge shows up as drain requests one register later. An acknowledge sampled at an edge moves the sequencer to BARRIER at that same edge, COMMIT follows one cycle after that, and FINISH comes one cycle after the last commit acknowledge or timeout. The bench drives inputs on the falling edge. It advances a behavioural model on each rising edge and compares every output a quarter period after that edge, so each result is checked in the cycle it is due. Emulated devices answer after a chosen number of cycles or never. This covers staggered pulses, timeouts in each phase, a zero timeout limit and retriggers while busy.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_DRAIN   = 3'd1,
        S_BARRIER = 3'd2,
        S_COMMIT  = 3'd3,
        S_FINISH  = 3'd4
    } fseq_state_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_DRAIN_T = 2'd1,
        ST_COMM_T  = 2'd2
    } fseq_status_e;
endpackage

// File: rtl/fseq_ack_track.sv
module fseq_ack_track #(
    parameter int N_DEV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [N_DEV-1:0] ack_i,
    output logic             all_o
);
    logic [N_DEV-1:0] seen_q;
    logic [N_DEV-1:0] have;

    for (genvar g = 0; g < N_DEV; g++) begin : g_dev
        assign have[g] = seen_q[g] | ack_i[g];
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) seen_q[g] <= 1'b0;
            else if (en_i)       seen_q[g] <= have[g];
        end
    end

    assign all_o = &have;
endmodule

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)                  cnt_q <= '0;
        else if (en_i && (cnt_q != '1))       cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q >= limit_i);
endmodule

// File: rtl/flush_seq.sv
module flush_seq
    import fseq_pkg::*;
#(
    parameter int N_DEV = 4,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic [N_DEV-1:0] drain_req_o,
    input  logic [N_DEV-1:0] drain_ack_i,
    output logic [N_DEV-1:0] commit_req_o,
    input  logic [N_DEV-1:0] commit_ack_i,
    output logic [N_DEV-1:0] fail_o,
    output logic             done_o,
    output logic [1:0]       status_o,
    output logic             busy_o
);
    fseq_state_e  state_q, state_d;
    fseq_status_e status_q;
    logic         fail_q;
    logic         in_phase, phase_clr;
    logic         all_drain, all_commit, expired;
    logic [N_DEV-1:0] ack_sel;
    logic         unused_all;

    assign in_phase  = (state_q == S_DRAIN) || (state_q == S_COMMIT);
    assign phase_clr = (state_q == S_IDLE) || (state_q == S_BARRIER);
    assign ack_sel   = (state_q == S_DRAIN) ? drain_ack_i : commit_ack_i;

    fseq_ack_track #(.N_DEV(N_DEV)) i_track (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (phase_clr),
        .en_i  (in_phase),
        .ack_i (ack_sel),
        .all_o (unused_all)
    );
    assign all_drain  = (state_q == S_DRAIN)  && unused_all;
    assign all_commit = (state_q == S_COMMIT) && unused_all;

    fseq_timer #(.TMO_W(TMO_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (phase_clr),
        .en_i      (in_phase),
        .limit_i   (tmo_limit_i),
        .expired_o (expired)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (trig_i) state_d = S_DRAIN;
            S_DRAIN:   if (all_drain || expired) state_d = S_BARRIER;
            S_BARRIER: state_d = S_COMMIT;
            S_COMMIT:  if (all_commit || expired) state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q   <= 1'b0;
            status_q <= ST_OK;
        end else begin
            if (state_q == S_IDLE && trig_i) begin
                fail_q   <= 1'b0;
                status_q <= ST_OK;
            end
            if (state_q == S_DRAIN && !all_drain && expired)
                fail_q <= 1'b1;
            if (state_q == S_COMMIT && (all_commit || expired)) begin
                if (fail_q)          status_q <= ST_DRAIN_T;
                else if (all_commit) status_q <= ST_OK;
                else                 status_q <= ST_COMM_T;
            end
        end
    end

    always_comb begin
        drain_req_o  = '0;
        commit_req_o = '0;
        fail_o       = '0;
        done_o       = 1'b0;
        busy_o       = (state_q != S_IDLE);
        status_o     = status_q;
        unique case (state_q)
            S_IDLE, S_BARRIER: ;
            S_DRAIN:   drain_req_o = '1;
            S_COMMIT: begin
                commit_req_o = '1;
                fail_o       = {N_DEV{fail_q}};
            end
            S_FINISH:  done_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
    parameter int N_DEV = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_i,
    input logic [N_DEV-1:0] drain_req_o,
    input logic [N_DEV-1:0] commit_req_o,
    input logic [N_DEV-1:0] fail_o,
    input logic             done_o,
    input logic [1:0]       status_o,
    input logic             busy_o
);
    AST_REQ_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req_o == '0) || (drain_req_o == '1)); // R2
    AST_NO_PHASE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !((|drain_req_o) && (|commit_req_o))); // R4
    AST_BARRIER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|drain_req_o) && busy_o |=> (|drain_req_o) || (commit_req_o == '0)); // R4
    AST_FAIL_WITH_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|fail_o) |-> (commit_req_o == '1) && (fail_o == '1)); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !busy_o); // R8
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        status_o != 2'd3); // R8
    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && trig_i |=> (drain_req_o == '1)); // R2
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o && !(|drain_req_o) |=> !(|drain_req_o)); // R9
endmodule

bind flush_seq fseq_chk #(.N_DEV(N_DEV)) i_fseq_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_i       (trig_i),
    .drain_req_o  (drain_req_o),
    .commit_req_o (commit_req_o),
    .fail_o       (fail_o),
    .done_o       (done_o),
    .status_o     (status_o),
    .busy_o       (busy_o)
);

// File: tb/test_flush_seq.sv
module test_flush_seq;
    localparam int N = 4;
    localparam int W = 16;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic [W-1:0] lim = 16'd8;
    logic [N-1:0] d_ack = '0, c_ack = '0;
    logic [N-1:0] d_req, c_req, fail;
    logic done, busy;
    logic [1:0] status;

    int checks = 0, fails = 0;
    int d1 [N];
    int d2 [N];
    int k1 [N];
    int k2 [N];
    int fail_seen;

    // behavioural model
    int m_ph = 0, m_cnt = 0, m_st = 0;
    bit m_fail = 0;
    logic [N-1:0] m_seen = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flush_seq #(.N_DEV(N), .TMO_W(W)) i_flush_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .tmo_limit_i(lim),
        .drain_req_o(d_req), .drain_ack_i(d_ack),
        .commit_req_o(c_req), .commit_ack_i(c_ack),
        .fail_o(fail), .done_o(done), .status_o(status), .busy_o(busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // emulated devices: ack pulse after the chosen delay, negative = never
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (d_req[i]) k1[i]++; else k1[i] = 0;
            d_ack[i] = (d1[i] >= 0) && (k1[i] == d1[i] + 1);
            if (c_req[i]) k2[i]++; else k2[i] = 0;
            c_ack[i] = (d2[i] >= 0) && (k2[i] == d2[i] + 1);
        end
    end

    always @(posedge clk) begin
        logic [N-1:0] a;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_st = 0; m_fail = 0; m_seen = '0;
        end else begin
            case (m_ph)
                0: if (trig) begin m_ph = 1; m_cnt = 0; m_seen = '0; m_fail = 0; m_st = 0; end
                1: begin
                    a = m_seen | d_ack;
                    if (&a) m_ph = 2;
                    else if (m_cnt >= lim) begin m_fail = 1; m_ph = 2; end
                    else m_cnt++;
                    m_seen = a;
                end
                2: begin m_ph = 3; m_cnt = 0; m_seen = '0; end
                3: begin
                    a = m_seen | c_ack;
                    if (&a) begin m_st = m_fail ? 1 : 0; m_ph = 4; end
                    else if (m_cnt >= lim) begin m_st = m_fail ? 1 : 2; m_ph = 4; end
                    else m_cnt++;
                    m_seen = a;
                end
                default: m_ph = 0;
            endcase
        end
        #(CLK_PERIOD/4);
        if (rst_n) begin
            chk(d_req == ((m_ph == 1) ? '1 : '0), "R3 drain_req", d_req, (m_ph == 1) ? 15 : 0);
            chk(c_req == ((m_ph == 3) ? '1 : '0), "R5 commit_req", c_req, (m_ph == 3) ? 15 : 0);
            chk(fail == ((m_ph == 3 && m_fail) ? '1 : '0), "R7 fail_o", fail, (m_ph == 3 && m_fail) ? 15 : 0);
            chk(done == (m_ph == 4), "R8 done_o", done, m_ph == 4);
            chk(status == m_st, "R8 status_o", status, m_st);
            chk(busy == (m_ph != 0), "R9 busy_o", busy, m_ph != 0);
            if (|fail) fail_seen++;
        end
    end

    task automatic run(input int a0, a1, a2, a3, b0, b1, b2, b3,
                       input int exp_st, input string tag);
        int n;
        d1[0] = a0; d1[1] = a1; d1[2] = a2; d1[3] = a3;
        d2[0] = b0; d2[1] = b1; d2[2] = b2; d2[3] = b3;
        fail_seen = 0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        chk(d_req == '1 && busy, "R2 start", d_req, 15);
        n = 0;
        while (!done && n < 200) begin @(posedge clk); #(CLK_PERIOD/4); n++; end
        chk(done == 1'b1, {tag, " done reached"}, done, 1);
        chk(status == exp_st, {tag, " status"}, status, exp_st);
        @(posedge clk); #(CLK_PERIOD/4);
        chk(!busy && !done && status == exp_st, "R8 hold after done", status, exp_st);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin d1[i] = 0; d2[i] = 0; k1[i] = 0; k2[i] = 0; end
        repeat (3) @(negedge clk);
        chk(d_req == 0 && c_req == 0 && fail == 0 && !done && !busy && status == 0,
            "R1 reset state", {d_req, c_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // staggered pulses, success
        run(0, 2, 1, 3, 1, 0, 0, 2, 0, "R3 R5 staggered");
        // drain timeout on device 2
        run(0, 0, -1, 0, 0, 0, 0, 0, 1, "R6 drain timeout");
        chk(fail_seen > 0, "R7 fail flag broadcast", fail_seen, 1);
        // commit timeout on device 0
        run(0, 0, 0, 0, -1, 0, 0, 0, 2, "R6 commit timeout");
        chk(fail_seen == 0, "R7 no fail on commit timeout", fail_seen, 0);
        // both time out: drain code wins
        run(-1, 0, 0, 0, 0, -1, 0, 0, 1, "R8 both timeout");
        // ack in the very last cycle still succeeds (limit 8 -> 9th cycle)
        run(8, 0, 0, 0, 0, 0, 0, 8, 0, "R6 last-cycle ack");
        // zero limit with immediate acks succeeds
        lim = 16'd0;
        run(0, 0, 0, 0, 0, 0, 0, 0, 0, "R6 zero limit");
        run(1, 0, 0, 0, 0, 0, 0, 0, 1, "R6 zero limit timeout");
        lim = 16'd8;
        // retrigger while busy
        d1[0] = 4; d1[1] = 0; d1[2] = 0; d1[3] = 0;
        for (int i = 0; i < N; i++) d2[i] = 0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        repeat (12) @(negedge clk);
        chk(!busy && d_req == 0, "R9 retrigger ignored", busy, 0);
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule